// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the byte-wide power control register of an 8051-style pager controller. It moves the core between three modes. In run mode everything is clocked. In idle mode the CPU clock stops but peripherals keep running. In power-down mode clocks stop and the DC/DC converter is switched off. Software enters idle or power-down by writing the register over the SFR bus. An enabled interrupt brings the core back from idle, and it resumes where it stopped.

Leaving power-down is not a resume. A wake source (minute tick, wake-up event, or any port 1 level request) first re-enables the DC/DC converter. Once the supply is reported good, the block holds the core in reset for a fixed number of cycles, so fetch restarts at address 0. Edge-type wake sources are kept as sticky flags in a second register, because as interrupts they are lost in the restart. Level requests on port 1 stay asserted at the inputs, so they need no flag.

The block also drives the ALE and PSEN pin levels for each mode, a UART double-rate flag, and a debug sync output that toggles on every instruction fetch.

Top module: `pmode_ctrl`

## Requirements
- R1: The power register answers at SFR address 0x87 as a whole byte: it resets to 0x00, a write in run mode stores the byte, and bit 4 is reserved and always reads 0.
- R2: Bit 7 drives `uart_x2`. Bit 6 (external RAM enable) and bits 3 and 2 (general flags) are stored and read back, and bit 6 has no effect on any output.
- R3: A write that sets bit 0 but not bit 1 enters idle from the next cycle: `cpu_clk_en`=0, `per_clk_en`=1, `dcdc_en`=1, and `ale_pin`=`psen_pin`=1.
- R4: In idle, `irq_pending`=1 returns the block to run mode on the next cycle with `cpu_clk_en`=1, clears bit 0 and keeps every other bit.
- R5: A write with bit 1 set enters power-down from the next cycle, even when bit 0 is also set: `cpu_clk_en`, `per_clk_en` and `dcdc_en` are 0, and `ale_pin`=`psen_pin`=0.
- R6: In power-down, a wake source sets `dcdc_en`=1 on the next cycle. After `supply_good` is seen high, `core_rst` is 1 for `RST_CYC` cycles with clocks off, then run mode resumes with the power register at 0x00.
- R7: The status register at 0x8F holds bit 0 = minute tick seen and bit 1 = wake event seen. Both are set by a one-cycle pulse in any mode and survive the power-down restart. A run-mode write of 1 to a bit clears it, and a pulse in the same cycle wins over the clear.
- R8: A wake from power-down caused only by a port 1 level request sets no status flag.
- R9: `sync_oe` equals bit 5. `sync_out` toggles on every `fetch_strobe` and is 0 after the power-down restart.
- R10: SFR writes are ignored while the core is not in run mode.
- R11: In run mode `ale_pin` and `psen_pin` follow `core_ale` and `core_psen`. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the addressed register |
| fetch_strobe | input | 1 | Start of an instruction fetch |
| irq_pending | input | 1 | An enabled interrupt is requesting service |
| minute_tick | input | 1 | Minute timer pulse (edge wake source) |
| wake_evt | input | 1 | Wake-up event pulse (edge wake source) |
| p1_lvl | input | P1W | Port 1 level interrupt requests |
| supply_good | input | 1 | Core supply at normal level |
| core_ale | input | 1 | ALE level from the core |
| core_psen | input | 1 | PSEN level from the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| dcdc_en | output | 1 | DC/DC converter enable |
| core_rst | output | 1 | Core reset after power-down wake |
| uart_x2 | output | 1 | UART double-rate select |
| sync_out | output | 1 | Fetch-sync debug level |
| sync_oe | output | 1 | Drive enable for the sync pin |
| ale_pin | output | 1 | ALE pin level |
| psen_pin | output | 1 | PSEN pin level |

## Verification
The mode logic is tried with a plain run-mode write, an idle write, a power-down write, and a write that sets both mode bits at once. The last one shows whether power-down wins the tie. Power-down is left once through each wake source, with the supply held low for several cycles first. This separates the ramp wait from the reset count. The minute and wake-up wakes must leave their own flag set, and the port 1 wake must leave both flags clear, which shows the edge sources are told apart from the level requests. Writes issued during idle, fetch strobes with the sync enable on and off, and a flag clear in the same cycle as a new pulse show that stored state changes only through the paths the requirements allow.

// File: rtl/pmode_ctrl.sv
module pmode_ctrl #(
  parameter logic [7:0] PCON_ADDR = 8'h87,
  parameter logic [7:0] STAT_ADDR = 8'h8F,
  parameter int         P1W       = 4,
  parameter int         RST_CYC   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     sfr_addr,
  input  logic           sfr_we,
  input  logic [7:0]     sfr_wdata,
  output logic [7:0]     sfr_rdata,
  input  logic           fetch_strobe,
  input  logic           irq_pending,
  input  logic           minute_tick,
  input  logic           wake_evt,
  input  logic [P1W-1:0] p1_lvl,
  input  logic           supply_good,
  input  logic           core_ale,
  input  logic           core_psen,
  output logic           cpu_clk_en,
  output logic           per_clk_en,
  output logic           dcdc_en,
  output logic           core_rst,
  output logic           uart_x2,
  output logic           sync_out,
  output logic           sync_oe,
  output logic           ale_pin,
  output logic           psen_pin
);

  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [7:0] KEEP_MASK = 8'hEF;

  typedef enum logic [2:0] {M_RUN, M_IDLE, M_PD, M_RAMP, M_RST} mode_t;

  mode_t          mode_q, mode_d;
  logic [7:0]     pcon_q;
  logic [CW-1:0]  cnt_q;
  logic           min_q, wk_q, sync_q;

  wire wr_ok    = sfr_we && (mode_q == M_RUN);
  wire wr_pcon  = wr_ok && (sfr_addr == PCON_ADDR);
  wire wr_stat  = wr_ok && (sfr_addr == STAT_ADDR);
  wire wake_any = minute_tick | wake_evt | (|p1_lvl);
  wire restart  = (mode_q == M_RAMP) && supply_good;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_RUN:  if (wr_pcon && sfr_wdata[1]) mode_d = M_PD;
              else if (wr_pcon && sfr_wdata[0]) mode_d = M_IDLE;
      M_IDLE: if (irq_pending) mode_d = M_RUN;
      M_PD:   if (wake_any) mode_d = M_RAMP;
      M_RAMP: if (supply_good) mode_d = M_RST;
      M_RST:  if (cnt_q == '0) mode_d = M_RUN;
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (restart) cnt_q <= CW'(RST_CYC - 1);
      else if (mode_q == M_RST && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcon_q <= '0;
    else if (restart) pcon_q <= '0;
    else if (wr_pcon) pcon_q <= sfr_wdata & KEEP_MASK;
    else if (mode_q == M_IDLE && irq_pending) pcon_q[0] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= 1'b0;
      wk_q   <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      min_q <= minute_tick | (min_q & ~(wr_stat & sfr_wdata[0]));
      wk_q  <= wake_evt    | (wk_q  & ~(wr_stat & sfr_wdata[1]));
      if (restart) sync_q <= 1'b0;
      else if (fetch_strobe) sync_q <= ~sync_q;
    end
  end

  assign sfr_rdata  = (sfr_addr == PCON_ADDR) ? pcon_q :
                      (sfr_addr == STAT_ADDR) ? {6'b0, wk_q, min_q} : 8'h00;
  assign cpu_clk_en = (mode_q == M_RUN);
  assign per_clk_en = (mode_q == M_RUN) || (mode_q == M_IDLE);
  assign dcdc_en    = (mode_q != M_PD);
  assign core_rst   = (mode_q == M_RST);
  assign uart_x2    = pcon_q[7];
  assign sync_oe    = pcon_q[5];
  assign sync_out   = sync_q;
  assign ale_pin    = (mode_q == M_RUN) ? core_ale  : (mode_q == M_IDLE);
  assign psen_pin   = (mode_q == M_RUN) ? core_psen : (mode_q == M_IDLE);

endmodule

module pmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       dcdc_en,
  input logic       core_rst,
  input logic       supply_good,
  input logic       irq_pending,
  input logic       fetch_strobe,
  input logic       sync_out,
  input logic       ale_pin,
  input logic       psen_pin,
  input logic [7:0] pcon_q
);
  // R3
  idle_pins_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en) |-> (ale_pin && psen_pin && dcdc_en));
  // R4
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && irq_pending) |=> cpu_clk_en);
  // R5
  pd_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dcdc_en |-> (!ale_pin && !psen_pin && !cpu_clk_en && !per_clk_en));
  // R6
  pd_no_direct_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dcdc_en |=> !cpu_clk_en);
  // R6
  rst_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> ($past(supply_good) && dcdc_en && !cpu_clk_en));
  // R9
  sync_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe && cpu_clk_en) |=> (sync_out != $past(sync_out)));
  // R10
  idle_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && !irq_pending) |=> $stable(pcon_q));
endmodule

bind pmode_ctrl pmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .dcdc_en(dcdc_en), .core_rst(core_rst), .supply_good(supply_good),
  .irq_pending(irq_pending), .fetch_strobe(fetch_strobe), .sync_out(sync_out),
  .ale_pin(ale_pin), .psen_pin(psen_pin), .pcon_q(pcon_q)
);

// File: tb/pmode_ctrl_bench.sv
module pmode_ctrl_bench;
  localparam int P1W = 4;
  localparam int RST_CYC = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic sfr_we = 0, fetch_strobe = 0, irq_pending = 0, minute_tick = 0, wake_evt = 0;
  logic [P1W-1:0] p1_lvl = 0;
  logic supply_good = 1, core_ale = 0, core_psen = 1;
  logic cpu_clk_en, per_clk_en, dcdc_en, core_rst, uart_x2, sync_out, sync_oe, ale_pin, psen_pin;

  int checks = 0, failures = 0, cycles = 0;

  pmode_ctrl #(.P1W(P1W), .RST_CYC(RST_CYC)) u_pmode_ctrl (.*);

  always #4 clk = ~clk;

  // behavioural reference: 0 run, 1 idle, 2 power-down, 3 ramp, 4 reset
  int m_mode = 0, m_cnt = 0;
  logic [7:0] m_pcon = 0;
  logic m_min = 0, m_wk = 0, m_sync = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_pcon = 0; m_min = 0; m_wk = 0; m_sync = 0;
    end else begin
      int nm;
      logic wok, clr0, clr1;
      nm = m_mode;
      wok = sfr_we && m_mode == 0;
      clr0 = wok && sfr_addr == 8'h8F && sfr_wdata[0];
      clr1 = wok && sfr_addr == 8'h8F && sfr_wdata[1];
      m_min = minute_tick || (m_min && !clr0);
      m_wk  = wake_evt || (m_wk && !clr1);
      if (m_mode == 3 && supply_good) m_sync = 0;
      else if (fetch_strobe) m_sync = !m_sync;
      case (m_mode)
        0: if (wok && sfr_addr == 8'h87) begin
             m_pcon = {sfr_wdata[7:5], 1'b0, sfr_wdata[3:0]};
             if (sfr_wdata[1]) nm = 2; else if (sfr_wdata[0]) nm = 1;
           end
        1: if (irq_pending) begin nm = 0; m_pcon[0] = 0; end
        2: if (minute_tick || wake_evt || p1_lvl != 0) nm = 3;
        3: if (supply_good) begin nm = 4; m_cnt = RST_CYC - 1; m_pcon = 0; end
        4: if (m_cnt == 0) nm = 0; else m_cnt--;
        default: nm = 0;
      endcase
      m_mode = nm;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      logic [7:0] er;
      logic ea, ep;
      er = sfr_addr == 8'h87 ? m_pcon : sfr_addr == 8'h8F ? {6'b0, m_wk, m_min} : 8'h00;
      ea = m_mode == 0 ? core_ale  : (m_mode == 1);
      ep = m_mode == 0 ? core_psen : (m_mode == 1);
      chk(sfr_addr == 8'h8F ? "R7 rdata" : "R1 rdata", sfr_rdata, er);
      chk("R3 cpu_clk_en", {7'b0, cpu_clk_en}, {7'b0, m_mode == 0});
      chk("R3 per_clk_en", {7'b0, per_clk_en}, {7'b0, m_mode <= 1});
      chk("R5 dcdc_en", {7'b0, dcdc_en}, {7'b0, m_mode != 2});
      chk("R6 core_rst", {7'b0, core_rst}, {7'b0, m_mode == 4});
      chk("R2 uart_x2", {7'b0, uart_x2}, {7'b0, m_pcon[7]});
      chk("R9 sync", {6'b0, sync_oe, sync_out}, {6'b0, m_pcon[5], m_sync});
      chk(m_mode == 0 ? "R11 pins" : "R5 pins", {6'b0, ale_pin, psen_pin}, {6'b0, ea, ep});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    @(negedge clk); sfr_we = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); sfr_addr = a; #2;
    chk(tag, sfr_rdata, exp);
  endtask

  task automatic pulse_min(); @(negedge clk); minute_tick = 1; @(negedge clk); minute_tick = 0; endtask
  task automatic pulse_wk();  @(negedge clk); wake_evt = 1;    @(negedge clk); wake_evt = 0;    endtask

  task automatic restart_wait();
    idle_cyc(3);
    supply_good = 1;
    idle_cyc(RST_CYC + 3);
  endtask

  initial begin
    idle_cyc(1); #2;
    chk("R1 reset rdata", sfr_rdata, 8'h00);
    chk("R3 reset clocks", {6'b0, cpu_clk_en, per_clk_en}, 8'h00 | 8'h03);
    rst_n = 1;
    idle_cyc(2);
    rd("R1 reset read", 8'h87, 8'h00);
    // R1 R2: store with reserved masked, bit 6 only read back
    wr(8'h87, 8'hDC);
    rd("R1 readback", 8'h87, 8'hCC);
    chk("R2 uart_x2 set", {7'b0, uart_x2}, 8'h01);
    wr(8'h87, 8'h40);
    rd("R2 bit6 kept", 8'h87, 8'h40);
    rd("R11 other addr", 8'h55, 8'h00);
    // R11 pins follow core
    @(negedge clk); core_ale = 1; core_psen = 0;
    @(negedge clk); core_ale = 0; core_psen = 1;
    // R9 fetch toggling, enable on then off
    wr(8'h87, 8'h20);
    for (int i = 0; i < 5; i++) begin @(negedge clk); fetch_strobe = 1; end
    @(negedge clk); fetch_strobe = 0;
    wr(8'h87, 8'h00);
    @(negedge clk); fetch_strobe = 1; @(negedge clk); fetch_strobe = 0;
    // R3 idle, R10 writes ignored, R4 exit
    wr(8'h87, 8'h4D);
    idle_cyc(2);
    wr(8'h87, 8'h00);
    rd("R10 idle write ignored", 8'h87, 8'h4D);
    @(negedge clk); irq_pending = 1; @(negedge clk); irq_pending = 0;
    rd("R4 idle bit cleared", 8'h87, 8'h4C);
    // R5 both bits: power-down wins; R6 minute wake
    wr(8'h87, 8'hA3);
    supply_good = 0;
    idle_cyc(4);
    pulse_min();
    restart_wait();
    rd("R6 pcon after restart", 8'h87, 8'h00);
    rd("R7 minute flag kept", 8'h8F, 8'h01);
    // R8 port 1 wake leaves flags alone
    wr(8'h8F, 8'h01);
    rd("R7 cleared", 8'h8F, 8'h00);
    wr(8'h87, 8'h02);
    supply_good = 0;
    idle_cyc(3);
    @(negedge clk); p1_lvl = 4'b0100; @(negedge clk); p1_lvl = 0;
    restart_wait();
    rd("R8 no flag from p1", 8'h8F, 8'h00);
    // wake event path
    wr(8'h87, 8'h02);
    supply_good = 0;
    idle_cyc(2);
    pulse_wk();
    restart_wait();
    rd("R7 wake flag kept", 8'h8F, 8'h02);
    // R7 set wins over clear in same cycle
    @(negedge clk); sfr_addr = 8'h8F; sfr_wdata = 8'h03; sfr_we = 1; wake_evt = 1;
    @(negedge clk); sfr_we = 0; wake_evt = 0;
    rd("R7 set beats clear", 8'h8F, 8'h02);
    idle_cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule